// File: doc/BRIEF.md
# Modulus Down-Counter Time Base

This block is a programmable down-counter that acts as a periodic time base inside a timer unit. Software writes a modulus value. The counter loads that value at once, then steps down by one on every tick from its own power-of-two prescaler. When the count steps from one to zero, the block sets a zero flag. The flag drives an interrupt request whenever the interrupt enable is set.

In periodic mode, the tick after zero reloads the modulus, so one period is modulus+1 ticks. In single-shot mode the count stays at zero. The zero event can also send a one-cycle latch strobe to neighbouring logic, which then copies its live capture values and accumulator counts into holding registers. That latch fires on every zero event in periodic mode. In single-shot mode it fires once per arm, and a write to the mode register re-arms it. The zero flag can be cleared in one of two ways, chosen by a mode input: by an explicit write-one-to-clear strobe, or by any access to the count register.

Top module: `mdc_top`

## Requirements
- R1: While `rst` is high and on the cycle after it, `count`, `zero_flag`, `irq` and `latch_strobe` are 0, and the single-shot latch is armed.
- R2: A cycle with `mod_wr` high puts `mod_val` on `count` on the following cycle. It also restarts the prescaler phase, so the first tick comes a full divisor period later.
- R3: When `precise` is 0, the tick divisor is 2 to the power `presc_sel[2:0]` (1 to 128). When `precise` is 1, it is 2 to the power min(`presc_sel`, 8) (1 to 256).
- R4: `count` changes only on a tick or a load. While `en` is 0 there are no ticks, the count holds and the prescaler phase resets.
- R5: A tick with `count` equal to 1 moves the count to 0 and sets `zero_flag` on the next cycle. In periodic mode (`periodic`=1), the next tick at zero reloads the modulus.
- R6: In single-shot mode (`periodic`=0), `count` stays at 0 once it reaches 0, until the next modulus write.
- R7: `irq` is the registered AND of the next flag value and `irq_en`. It is therefore never high while `zero_flag` is low.
- R8: With `fast_clr`=0, `flag_w1c` clears the flag and `cnt_acc` has no effect on it.
- R9: With `fast_clr`=1, `cnt_acc` (any read or write of the count) clears the flag and `flag_w1c` has no effect on it.
- R10: A zero event in the same cycle as a clear leaves the flag set.
- R11: With `latch_on`=1 and `periodic`=1, `latch_strobe` is a one-cycle pulse on every zero event, aligned with the flag setting. With `latch_on`=0 it stays low.
- R12: In single-shot mode, `latch_strobe` pulses only on the first zero event after an arm. A `cfg_wr` pulse re-arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Counter and prescaler enable |
| periodic | input | 1 | 1 = reload and repeat, 0 = single shot |
| latch_on | input | 1 | Allow latch strobe on zero events |
| irq_en | input | 1 | Interrupt enable |
| fast_clr | input | 1 | Select clearing the flag by count-register access |
| precise | input | 1 | Extended prescaler range |
| presc_sel | input | 4 | Prescaler exponent |
| cfg_wr | input | 1 | Mode register write strobe, re-arms single-shot latch |
| mod_wr | input | 1 | Modulus write strobe |
| mod_val | input | 16 | Modulus value |
| cnt_acc | input | 1 | Count register read or write strobe |
| flag_w1c | input | 1 | Write-one-to-clear strobe for the zero flag |
| count | output | 16 | Current count |
| zero_flag | output | 1 | Zero flag |
| irq | output | 1 | Interrupt request |
| latch_strobe | output | 1 | Holding-register latch pulse |

## Verification
A wrong count or prescaler phase shows up within one tick. The `count` value drifts, and the zero event then arrives a tick early or late, which moves `zero_flag`, `irq` and `latch_strobe` with it. A wrong arm state or clear-path selection in the flag and latch logic is invisible until the next zero event or clear strobe. At that point the port values differ from the reference model on the following cycle. The bench compares all four outputs against the model on every clock, so any such fault is reported in the first cycle where it reaches a port.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  // Effective prescaler exponent: normal mode keeps the low bits only,
  // precision mode saturates the full field at the maximum exponent.
  function automatic int unsigned eff_shift(input int unsigned sel,
                                            input bit precise,
                                            input int unsigned norm_bits,
                                            input int unsigned max_log);
    if (precise)
      return (sel > max_log) ? max_log : sel;
    else
      return sel % (32'd1 << norm_bits);
  endfunction
endpackage

// File: rtl/mdc_prescaler.sv
module mdc_prescaler #(
  parameter int PRE_LOG = 8,
  parameter int SEL_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic             precise,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  import mdc_pkg::*;
  localparam int NORM_BITS = SEL_W - 1;
  localparam logic [PRE_LOG-1:0] PH_ONE = PRE_LOG'(1);

  logic [PRE_LOG-1:0] ph_q;
  logic [PRE_LOG-1:0] mask;
  int unsigned        shift;

  always_comb begin
    shift = eff_shift(32'(sel), precise, NORM_BITS, PRE_LOG);
    for (int i = 0; i < PRE_LOG; i++)
      mask[i] = (32'(i) < shift);
  end

  assign tick = en && ((ph_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart || !en) ph_q <= '0;
    else                       ph_q <= ph_q + PH_ONE;
  end

  // R4
  no_tick_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> !tick);
endmodule

// File: rtl/mdc_counter.sv
module mdc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mod_wr,
  input  logic [CNT_W-1:0] mod_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] cnt_q,
  output logic             zero_ev
);
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

  logic [CNT_W-1:0] modr_q;

  assign zero_ev = !mod_wr && tick && (cnt_q == C_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      modr_q <= '0;
    end else if (mod_wr) begin
      cnt_q  <= mod_val;
      modr_q <= mod_val;
    end else if (tick) begin
      if (cnt_q != '0) cnt_q <= cnt_q - C_ONE;
      else if (periodic) cnt_q <= modr_q;
    end
  end

  // R2
  mod_load_chk: assert property (@(posedge clk) disable iff (rst)
    mod_wr |=> cnt_q == $past(mod_val));
  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mod_wr && !tick) |=> $stable(cnt_q));
  // R6
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mod_wr && !periodic && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/mdc_events.sv
module mdc_events (
  input  logic clk,
  input  logic rst,
  input  logic zero_ev,
  input  logic irq_en,
  input  logic fast_clr,
  input  logic flag_w1c,
  input  logic cnt_acc,
  input  logic latch_on,
  input  logic periodic,
  input  logic cfg_wr,
  output logic flag_q,
  output logic irq_q,
  output logic latch_q
);
  logic armed_q;
  logic clr;
  logic flag_d;
  logic fire;

  always_comb begin
    clr    = fast_clr ? cnt_acc : flag_w1c;
    flag_d = zero_ev ? 1'b1 : (clr ? 1'b0 : flag_q);
    fire   = zero_ev && latch_on && (periodic || armed_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
      latch_q <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      flag_q  <= flag_d;
      irq_q   <= flag_d && irq_en;
      latch_q <= fire;
      if (cfg_wr)                      armed_q <= 1'b1;
      else if (fire && !periodic)      armed_q <= 1'b0;
    end
  end

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    zero_ev |=> flag_q);
  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q);
  // R11
  latch_with_flag_chk: assert property (@(posedge clk) disable iff (rst)
    latch_q |-> flag_q);
  // R11
  latch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    latch_q |=> !latch_q);
  // R9
  fast_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (fast_clr && cnt_acc && !zero_ev) |=> !flag_q);
endmodule

// File: rtl/mdc_top.sv
module mdc_top #(
  parameter int CNT_W   = 16,
  parameter int PRE_LOG = 8,
  parameter int SEL_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             periodic,
  input  logic             latch_on,
  input  logic             irq_en,
  input  logic             fast_clr,
  input  logic             precise,
  input  logic [SEL_W-1:0] presc_sel,
  input  logic             cfg_wr,
  input  logic             mod_wr,
  input  logic [CNT_W-1:0] mod_val,
  input  logic             cnt_acc,
  input  logic             flag_w1c,
  output logic [CNT_W-1:0] count,
  output logic             zero_flag,
  output logic             irq,
  output logic             latch_strobe
);
  logic tick;
  logic zero_ev;

  mdc_prescaler #(.PRE_LOG(PRE_LOG), .SEL_W(SEL_W)) i_pre (
    .clk(clk), .rst(rst), .en(en), .restart(mod_wr),
    .precise(precise), .sel(presc_sel), .tick(tick)
  );

  mdc_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .mod_wr(mod_wr), .mod_val(mod_val),
    .tick(tick), .periodic(periodic), .cnt_q(count), .zero_ev(zero_ev)
  );

  mdc_events i_evt (
    .clk(clk), .rst(rst), .zero_ev(zero_ev), .irq_en(irq_en),
    .fast_clr(fast_clr), .flag_w1c(flag_w1c), .cnt_acc(cnt_acc),
    .latch_on(latch_on), .periodic(periodic), .cfg_wr(cfg_wr),
    .flag_q(zero_flag), .irq_q(irq), .latch_q(latch_strobe)
  );
endmodule

// File: tb/test_mdc_top.sv
module test_mdc_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 0, periodic = 0, latch_on = 0, irq_en = 0, fast_clr = 0, precise = 0;
  logic [3:0] presc_sel = 0;
  logic cfg_wr = 0, mod_wr = 0, cnt_acc = 0, flag_w1c = 0;
  logic [15:0] mod_val = 0;
  logic [15:0] count;
  logic zero_flag, irq, latch_strobe;

  always #2 clk = ~clk;

  mdc_top i_mdc_top (
    .clk(clk), .rst(rst), .en(en), .periodic(periodic), .latch_on(latch_on),
    .irq_en(irq_en), .fast_clr(fast_clr), .precise(precise),
    .presc_sel(presc_sel), .cfg_wr(cfg_wr), .mod_wr(mod_wr),
    .mod_val(mod_val), .cnt_acc(cnt_acc), .flag_w1c(flag_w1c),
    .count(count), .zero_flag(zero_flag), .irq(irq),
    .latch_strobe(latch_strobe)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_cnt, m_mod, m_phase;
  bit m_flag, m_irq, m_latch, m_armed;

  function automatic int divisor();
    int s;
    if (precise) s = (presc_sel > 8) ? 8 : int'(presc_sel);
    else         s = int'(presc_sel) % 8;
    return 1 << s;
  endfunction

  task automatic model_update();
    bit ev = 0;
    bit clr;
    if (rst) begin
      m_cnt = 0; m_mod = 0; m_phase = 0;
      m_flag = 0; m_irq = 0; m_latch = 0; m_armed = 1;
      return;
    end
    if (mod_wr) begin
      m_cnt = int'(mod_val); m_mod = int'(mod_val); m_phase = 0;
    end else if (!en) begin
      m_phase = 0;
    end else begin
      if ((m_phase + 1) % divisor() == 0) begin
        if (m_cnt > 1) m_cnt = m_cnt - 1;
        else if (m_cnt == 1) begin m_cnt = 0; ev = 1; end
        else if (periodic) m_cnt = m_mod;
      end
      m_phase = (m_phase + 1) % 256;
    end
    clr = fast_clr ? cnt_acc : flag_w1c;
    if (ev) m_flag = 1;
    else if (clr) m_flag = 0;
    m_irq = m_flag && irq_en;
    m_latch = ev && latch_on && (periodic || m_armed);
    if (cfg_wr) m_armed = 1;
    else if (m_latch && !periodic) m_armed = 0;
  endtask

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_update();
      @(negedge clk);
      chk("count", int'(count), m_cnt);
      chk("zero_flag", int'(zero_flag), int'(m_flag));
      chk("irq", int'(irq), int'(m_irq));
      chk("latch_strobe", int'(latch_strobe), int'(m_latch));
    end
  endtask

  task automatic load(input int v);
    mod_val = 16'(v); mod_wr = 1; step(1); mod_wr = 0;
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R1"; step(3);
    rst = 0; step(2);

    cur_req = "R2"; en = 1; periodic = 1; irq_en = 1; latch_on = 1;
    load(5); step(3);
    cur_req = "R5"; step(12);
    cur_req = "R7"; irq_en = 0; step(6); irq_en = 1; step(8);
    cur_req = "R11"; step(14);
    latch_on = 0; step(14); latch_on = 1;

    cur_req = "R4"; en = 0; step(8); en = 1; step(4);

    cur_req = "R3"; presc_sel = 2; load(3); step(40);
    precise = 1; presc_sel = 9; load(2); step(800);
    precise = 0; step(20);
    precise = 1; presc_sel = 5; load(1); step(80);
    precise = 0; presc_sel = 0;

    cur_req = "R6"; periodic = 0; load(3); step(10);
    cur_req = "R12"; cfg_wr = 1; step(1); cfg_wr = 0;
    load(2); step(6);
    load(2); step(6);
    cfg_wr = 1; step(1); cfg_wr = 0;
    load(1); step(4);

    cur_req = "R8"; fast_clr = 0; load(1); step(3);
    cnt_acc = 1; step(2); cnt_acc = 0; step(1);
    flag_w1c = 1; step(1); flag_w1c = 0; step(2);
    cur_req = "R9"; fast_clr = 1; load(1); step(3);
    flag_w1c = 1; step(2); flag_w1c = 0; step(1);
    cnt_acc = 1; step(1); cnt_acc = 0; step(2);

    cur_req = "R10"; periodic = 1; fast_clr = 0; flag_w1c = 1; load(1); step(12);
    fast_clr = 1; flag_w1c = 0; cnt_acc = 1; step(12); cnt_acc = 0;
    step(4);

    cur_req = "R1"; rst = 1; step(2); rst = 0; step(2);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule